// File: doc/BRIEF.md
# Cache Line Fill Controller

This block sits between a requester that issues cachable long-word reads and a 32-bit external bus. It keeps a small direct-mapped cache: a tag store (upper address bits plus the access function code), a valid bit per long-word entry, and the entry data. Each accepted read is looked up. A hit is answered from the cache. A miss is filled from the bus, either as one long word or as a four-beat burst that wraps around the line.

A burst is requested when the line's tag does not match, or when the tag matches but every entry of the line is invalid. The cache and burst filling must both be enabled. The burst carries on only while the slave acknowledges it. Each beat ends with a synchronous termination strobe that delivers one long word. The requested long word is always the first beat, and it is passed to the requester in the cycle it arrives.

The controller has three states. IDLE accepts a request (IDLE→LOOKUP). LOOKUP compares tag and valid bits: a hit answers and goes back (LOOKUP→IDLE); any other case goes to the bus (LOOKUP→FILL), and a tag miss rewrites the tag and clears the line's valid bits on that edge. FILL holds the bus request. A strobe with the burst acknowledge, on a burst that is not at its last beat, advances to the next entry (FILL→FILL). A strobe with no acknowledge, the last beat, or a bus error ends the fill (FILL→IDLE).

Top module: `cache_fill_ctrl`

## Requirements
- R1: A long-word address (byte address bits 31..2) splits into entry = bits 3..2, line = bits 7..4 and tag = bits 31..8; a line matches only when both the stored tag and the stored 3-bit function code equal the request's.
- R2: A read that matches the line tag and finds its entry valid (with cache_en high) raises resp_valid with the stored data in the cycle after acceptance, and bus_req stays low.
- R3: When the tag matches, the addressed entry is invalid and at least one other entry of the line is valid, the controller performs a single transfer (bus_burst low) to the requested address and only that entry becomes valid.
- R4: bus_burst is raised, during the first transfer of a fill only, when cache_en and burst_en are high and the tag misses or all four entries are invalid; with burst_en low such a miss is a single transfer.
- R5: On a tag miss the tag and function code are overwritten and all four valid bits are cleared before any data is written, so entries of the evicted line no longer hit.
- R6: Burst transfers start at the requested entry and step through the line modulo four; bus_addr keeps the line and tag fixed for the whole fill.
- R7: The requested long word appears on resp_data with resp_valid in the same cycle as its strobe (first beat), and resp_valid is raised once per request.
- R8: If bus_cback is low at the first strobe, the fill ends after that beat and only the requested entry becomes valid.
- R9: If bus_cback is low at a later strobe, that beat is still written and the burst ends; received entries are valid and the rest stay invalid.
- R10: A bus error ends the fill and leaves its entry invalid; on the first beat it is reported as resp_valid with resp_err, on a later beat no further response is given.
- R11: With cache_en low a read never hits; it goes to the bus as one transfer without burst and nothing in the cache is changed.
- R12: req_ready is high only in the idle state, and req_valid while the controller is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Cache enable |
| burst_en | input | 1 | Burst filling enable |
| req_valid | input | 1 | Read request, sampled when req_ready is high |
| req_addr | input | 30 | Long-word address (byte address bits 31..2) |
| req_fc | input | 3 | Access function code |
| req_ready | output | 1 | Controller idle, ready for a request |
| resp_valid | output | 1 | Response strobe |
| resp_err | output | 1 | Response carries a bus error |
| resp_data | output | 32 | Returned long word |
| bus_req | output | 1 | External transfer in progress |
| bus_burst | output | 1 | Burst request on the first transfer |
| bus_addr | output | 30 | Long-word address of the current transfer |
| bus_cback | input | 1 | Slave burst acknowledge |
| bus_sterm | input | 1 | Synchronous termination strobe, one long word per strobe |
| bus_berr | input | 1 | Bus error termination |
| bus_data | input | 32 | Read data from the slave |

## Verification
The bench builds the block with its default parameters: sixteen lines of four entries, a data-style tag that compares all three function-code bits, and a 32-bit address. Four entries per line make every wrap point of a burst reachable from the four start entries, and the full function-code compare lets the same address with another code force a tag miss on a line that holds valid data. The reset tag value of zero lets a low address reach the "tag matches but line empty" burst case without any prior fill.

// File: rtl/cfill_pkg.sv
package cfill_pkg;

    localparam int BYTE_OFF_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } fill_state_e;

endpackage

// File: rtl/cfill_tag_array.sv
module cfill_tag_array #(
    parameter int LINES       = 16,
    parameter int WORDS       = 4,
    parameter int TAG_W       = 24,
    parameter int FC_W        = 3,
    parameter bit INSTR_CACHE = 1'b0,
    localparam int LINE_W     = $clog2(LINES),
    localparam int ENT_W      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [FC_W-1:0]   look_fc,
    output logic              tag_match,
    output logic [WORDS-1:0]  valid_vec,
    input  logic              alloc_we,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [FC_W-1:0]   alloc_fc,
    input  logic              set_we,
    input  logic [ENT_W-1:0]  set_entry
);

    localparam int KEY_W = INSTR_CACHE ? 1 : FC_W;

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [KEY_W-1:0] key_q   [LINES];
    logic [WORDS-1:0] valid_q [LINES];
    logic [KEY_W-1:0] look_key;
    logic [KEY_W-1:0] alloc_key;

    generate
        if (INSTR_CACHE) begin : g_instr_key
            assign look_key  = look_fc[FC_W-1];
            assign alloc_key = alloc_fc[FC_W-1];
        end else begin : g_data_key
            assign look_key  = look_fc;
            assign alloc_key = alloc_fc;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]   <= '0;
                key_q[i]   <= '0;
                valid_q[i] <= '0;
            end
        end else begin
            if (alloc_we) begin
                tag_q[look_line]   <= alloc_tag;
                key_q[look_line]   <= alloc_key;
                valid_q[look_line] <= '0;
            end else if (set_we) begin
                valid_q[look_line][set_entry] <= 1'b1;
            end
        end
    end

    assign tag_match = (tag_q[look_line] == look_tag) && (key_q[look_line] == look_key);
    assign valid_vec = valid_q[look_line];

    AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_we |=> (look_line != $past(look_line) || valid_vec == '0)); // R5

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> valid_q[$past(look_line)][$past(set_entry)]); // R3

endmodule

// File: rtl/cfill_data_array.sv
module cfill_data_array #(
    parameter int LINES   = 16,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    localparam int LINE_W = $clog2(LINES),
    localparam int ENT_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [LINE_W-1:0] line,
    input  logic              wr_en,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[line][wr_entry] <= wr_data;
        end
    end

    assign rd_data = mem_q[line][rd_entry];

endmodule

// File: rtl/cfill_ctrl_fsm.sv
module cfill_ctrl_fsm
    import cfill_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int FC_W    = 3,
    parameter int LINE_W  = 4,
    parameter int ENT_W   = 2,
    parameter int WORDS   = 4,
    localparam int TAG_W  = ADDR_W - BYTE_OFF_W - ENT_W - LINE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cache_en,
    input  logic                     burst_en,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:BYTE_OFF_W] req_addr,
    input  logic [FC_W-1:0]          req_fc,
    output logic                     req_ready,
    output logic                     resp_valid,
    output logic                     resp_err,
    output logic [DATA_W-1:0]        resp_data,
    output logic                     bus_req,
    output logic                     bus_burst,
    output logic [ADDR_W-1:BYTE_OFF_W] bus_addr,
    input  logic                     bus_cback,
    input  logic                     bus_sterm,
    input  logic                     bus_berr,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic                     tag_match,
    input  logic [WORDS-1:0]         valid_vec,
    input  logic [DATA_W-1:0]        rd_data,
    output logic [LINE_W-1:0]        lk_line,
    output logic [TAG_W-1:0]         lk_tag,
    output logic [FC_W-1:0]          lk_fc,
    output logic [ENT_W-1:0]         rd_entry,
    output logic                     alloc_we,
    output logic                     set_we,
    output logic [ENT_W-1:0]         set_entry
);

    localparam int ENT_LSB  = BYTE_OFF_W;
    localparam int LINE_LSB = ENT_LSB + ENT_W;
    localparam int TAG_LSB  = LINE_LSB + LINE_W;
    localparam logic [ENT_W-1:0] LAST_BEAT = ENT_W'(WORDS - 1);

    fill_state_e state_q, state_d;
    logic [ADDR_W-1:BYTE_OFF_W] addr_q, addr_d;
    logic [FC_W-1:0]  fc_q, fc_d;
    logic             burst_q, burst_d;
    logic             alloc_q, alloc_d;
    logic [ENT_W-1:0] beat_q, beat_d;
    logic [ENT_W-1:0] ent_q, ent_d;

    logic             hit;
    logic             line_empty;
    logic             term;
    logic             more;

    assign lk_line  = addr_q[LINE_LSB +: LINE_W];
    assign lk_tag   = addr_q[ADDR_W-1:TAG_LSB];
    assign lk_fc    = fc_q;
    assign rd_entry = addr_q[ENT_LSB +: ENT_W];

    assign hit        = cache_en && tag_match && valid_vec[rd_entry];
    assign line_empty = (valid_vec == '0);
    assign term       = bus_sterm || bus_berr;
    assign more       = burst_q && bus_cback && !bus_berr && (beat_q != LAST_BEAT);

    // Next state and context
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        fc_d    = fc_q;
        burst_d = burst_q;
        alloc_d = alloc_q;
        beat_d  = beat_q;
        ent_d   = ent_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    addr_d  = req_addr;
                    fc_d    = req_fc;
                    state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    state_d = ST_IDLE;
                end else begin
                    burst_d = cache_en && burst_en && (!tag_match || line_empty);
                    alloc_d = cache_en;
                    beat_d  = '0;
                    ent_d   = rd_entry;
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (term) begin
                    if (more) begin
                        beat_d = beat_q + 1'b1;
                        ent_d  = ent_q + 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            fc_q    <= '0;
            burst_q <= 1'b0;
            alloc_q <= 1'b0;
            beat_q  <= '0;
            ent_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            fc_q    <= fc_d;
            burst_q <= burst_d;
            alloc_q <= alloc_d;
            beat_q  <= beat_d;
            ent_q   <= ent_d;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        resp_data  = '0;
        bus_req    = 1'b0;
        bus_burst  = 1'b0;
        bus_addr   = '0;
        alloc_we   = 1'b0;
        set_we     = 1'b0;
        set_entry  = ent_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                resp_valid = hit;
                resp_data  = hit ? rd_data : '0;
                alloc_we   = cache_en && !hit && !tag_match;
            end
            ST_FILL: begin
                bus_req    = 1'b1;
                bus_burst  = burst_q && (beat_q == '0);
                bus_addr   = {lk_tag, lk_line, ent_q};
                set_we     = alloc_q && bus_sterm && !bus_berr;
                resp_valid = term && (beat_q == '0);
                resp_err   = resp_valid && bus_berr;
                resp_data  = (resp_valid && !bus_berr) ? bus_data : '0;
            end
            default: ;
        endcase
    end

    AST_BURST_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst |-> bus_req); // R4

    AST_RESP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R7

    AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_valid); // R10

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !resp_valid)); // R12

    AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_sterm && !bus_berr) |=>
            (!bus_req || bus_addr[ENT_LSB +: ENT_W] == ENT_W'($past(bus_addr[ENT_LSB +: ENT_W]) + 1'b1))); // R6

    AST_LINE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> (bus_addr[ADDR_W-1:LINE_LSB] == $past(bus_addr[ADDR_W-1:LINE_LSB]))); // R6

endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl
    import cfill_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int FC_W        = 3,
    parameter int LINES       = 16,
    parameter int WORDS       = 4,
    parameter bit INSTR_CACHE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cache_en,
    input  logic                       burst_en,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:BYTE_OFF_W] req_addr,
    input  logic [FC_W-1:0]            req_fc,
    output logic                       req_ready,
    output logic                       resp_valid,
    output logic                       resp_err,
    output logic [DATA_W-1:0]          resp_data,
    output logic                       bus_req,
    output logic                       bus_burst,
    output logic [ADDR_W-1:BYTE_OFF_W] bus_addr,
    input  logic                       bus_cback,
    input  logic                       bus_sterm,
    input  logic                       bus_berr,
    input  logic [DATA_W-1:0]          bus_data
);

    localparam int LINE_W = $clog2(LINES);
    localparam int ENT_W  = $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - BYTE_OFF_W - ENT_W - LINE_W;

    logic              tag_match;
    logic [WORDS-1:0]  valid_vec;
    logic [DATA_W-1:0] rd_data;
    logic [LINE_W-1:0] lk_line;
    logic [TAG_W-1:0]  lk_tag;
    logic [FC_W-1:0]   lk_fc;
    logic [ENT_W-1:0]  rd_entry;
    logic              alloc_we;
    logic              set_we;
    logic [ENT_W-1:0]  set_entry;

    cfill_ctrl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W),
        .LINE_W(LINE_W), .ENT_W(ENT_W), .WORDS(WORDS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cache_en(cache_en), .burst_en(burst_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_fc(req_fc),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_data(resp_data),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr),
        .bus_cback(bus_cback), .bus_sterm(bus_sterm), .bus_berr(bus_berr),
        .bus_data(bus_data),
        .tag_match(tag_match), .valid_vec(valid_vec), .rd_data(rd_data),
        .lk_line(lk_line), .lk_tag(lk_tag), .lk_fc(lk_fc), .rd_entry(rd_entry),
        .alloc_we(alloc_we), .set_we(set_we), .set_entry(set_entry)
    );

    cfill_tag_array #(
        .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W), .FC_W(FC_W),
        .INSTR_CACHE(INSTR_CACHE)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_line(lk_line), .look_tag(lk_tag), .look_fc(lk_fc),
        .tag_match(tag_match), .valid_vec(valid_vec),
        .alloc_we(alloc_we), .alloc_tag(lk_tag), .alloc_fc(lk_fc),
        .set_we(set_we), .set_entry(set_entry)
    );

    cfill_data_array #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk), .line(lk_line),
        .wr_en(set_we), .wr_entry(set_entry), .wr_data(bus_data),
        .rd_entry(rd_entry), .rd_data(rd_data)
    );

endmodule

// File: tb/sim_cache_fill_ctrl.sv
`timescale 1ns/1ps
module sim_cache_fill_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0, burst_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:2] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic        req_ready, resp_valid, resp_err, bus_req, bus_burst;
    logic [31:0] resp_data;
    logic [31:2] bus_addr;
    logic        bus_cback = 1'b0, bus_sterm = 1'b0, bus_berr = 1'b0;
    logic [31:0] bus_data = '0;

    int errors = 0;
    int checks = 0;
    int salt = 0;
    bit done = 1'b0;

    logic [23:0] mtag [16];
    logic [2:0]  mfc  [16];
    bit          mval [16][4];
    logic [31:0] mdat [16][4];

    always #10 clk = ~clk;

    cache_fill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .burst_en(burst_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_fc(req_fc),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_data(resp_data), .bus_req(bus_req), .bus_burst(bus_burst),
        .bus_addr(bus_addr), .bus_cback(bus_cback), .bus_sterm(bus_sterm),
        .bus_berr(bus_berr), .bus_data(bus_data)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic quiet();
        bus_sterm = 1'b0; bus_berr = 1'b0; bus_cback = 1'b0; bus_data = '0;
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0] ^ 16'(salt * 16'h1357), a[31:16]};
    endfunction

    task automatic bus_cycle_checks(input logic [31:0] exp_addr, input bit exp_burst);
        chk("R6 bus_addr", {bus_addr, 2'b00}, exp_addr);
        chk("R4 bus_burst", bus_burst, exp_burst);
        chk("R12 bus_req busy", bus_req, 1'b1);
    endtask

    // One read: a = byte address, f = fc; nack: beats b>0 see cback = (b < nack)
    task automatic do_read(input logic [31:0] a, input logic [2:0] f, input bit cen, input bit ben,
                           input bit ack, input int nack, input int berr_at, input int waits, input bit poke);
        logic [3:0]  ln;
        logic [1:0]  cur;
        logic [23:0] tg;
        bit tm, hit, burst, go, empty, be, cb;
        int beat;
        logic [31:0] w;
        ln = a[7:4]; cur = a[3:2]; tg = a[31:8];
        salt++;
        @(negedge clk); quiet();
        chk("R12 ready in idle", req_ready, 1'b1);
        chk("R12 idle no bus", bus_req, 1'b0);
        cache_en = cen; burst_en = ben;
        req_valid = 1'b1; req_addr = a[31:2]; req_fc = f;
        @(negedge clk); quiet();
        req_addr = '0;
        tm = (mtag[ln] == tg) && (mfc[ln] == f);
        empty = !(mval[ln][0] || mval[ln][1] || mval[ln][2] || mval[ln][3]);
        hit = cen && tm && mval[ln][cur];
        chk("R2 lookup hit", resp_valid, hit);
        chk("R12 busy not ready", req_ready, 1'b0);
        chk("R2 no bus in lookup", bus_req, 1'b0);
        if (hit) begin
            chk("R2 hit data", resp_data, mdat[ln][cur]);
            return;
        end
        burst = cen && ben && (!tm || empty);
        if (cen && !tm) begin
            mtag[ln] = tg; mfc[ln] = f;
            for (int i = 0; i < 4; i++) mval[ln][i] = 1'b0;
        end
        beat = 0; go = 1'b1;
        while (go) begin
            for (int k = 0; k < waits; k++) begin
                @(negedge clk); quiet();
                bus_cycle_checks({tg, ln, cur, 2'b00}, burst && beat == 0);
                if (poke && k == 0) begin
                    req_valid = 1'b1; req_addr = a[31:2] ^ 30'h40; req_fc = ~f;
                end
                #1 chk("R7 no resp before strobe", resp_valid, 1'b0);
            end
            @(negedge clk); quiet();
            bus_cycle_checks({tg, ln, cur, 2'b00}, burst && beat == 0);
            be = (beat == berr_at);
            cb = (beat == 0) ? ack : (beat < nack);
            w  = word_of({tg, ln, cur, 2'b00});
            bus_sterm = 1'b1; bus_berr = be; bus_cback = cb; bus_data = w;
            #1;
            if (beat == 0) begin
                chk("R7 resp on first strobe", resp_valid, 1'b1);
                chk("R10 resp_err", resp_err, be);
                if (!be) chk("R7 resp data", resp_data, w);
            end else begin
                chk("R10 no resp on later beat", resp_valid, 1'b0);
            end
            if (!be && cen) begin
                mval[ln][cur] = 1'b1;
                mdat[ln][cur] = w;
            end
            go = !be && burst && cb && beat < 3;
            beat++;
            cur = cur + 2'd1;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mtag[i] = '0; mfc[i] = '0;
            for (int j = 0; j < 4; j++) begin mval[i][j] = 1'b0; mdat[i][j] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ready", req_ready, 1'b1);
        chk("R12 reset bus_req", bus_req, 1'b0);
        chk("R7 reset resp_valid", resp_valid, 1'b0);

        // R4 R6 R7: full wrapping burst from entry 2 of line 1 (R1 split)
        do_read(32'h0000_1218, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R2: hits on every entry of the line
        do_read(32'h0000_1210, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_1214, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_121C, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R1 R5 R8: other function code misses, burst refused
        do_read(32'h0000_1218, 3'd5, 1, 1, 0, 4, -1, 0, 0);
        // R3: entry fill on matching tag
        do_read(32'h0000_1210, 3'd5, 1, 1, 1, 4, -1, 0, 0);
        // R5: old code now misses
        do_read(32'h0000_1218, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R9: burst cut short after three beats
        do_read(32'h0000_4434, 3'd2, 1, 1, 1, 2, -1, 0, 0);
        do_read(32'h0000_4438, 3'd2, 1, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_4430, 3'd2, 1, 1, 1, 4, -1, 0, 0);
        // R4: tag matches reset state, line empty -> burst
        do_read(32'h0000_0064, 3'd0, 1, 1, 1, 4, -1, 0, 0);
        // R4: burst disabled -> single
        do_read(32'h0000_7750, 3'd1, 1, 0, 1, 4, -1, 0, 0);
        do_read(32'h0000_7754, 3'd1, 1, 0, 1, 4, -1, 0, 0);
        // R10: error on first beat, then refill
        do_read(32'h0000_9980, 3'd1, 1, 1, 1, 4, 0, 0, 0);
        do_read(32'h0000_9980, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R10: error on third beat
        do_read(32'h0000_AA90, 3'd1, 1, 1, 1, 4, 2, 0, 0);
        do_read(32'h0000_AA98, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_AA9C, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R11: cache disabled: bypass, no allocation, no hit on valid line
        do_read(32'h0000_BBA0, 3'd1, 0, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_1218, 3'd1, 0, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_BBA0, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        // R12: wait states with an ignored request during the fill
        do_read(32'h0000_CCB4, 3'd3, 1, 1, 1, 4, -1, 2, 1);
        do_read(32'h0000_CCB8, 3'd3, 1, 1, 1, 4, -1, 0, 0);
        do_read(32'h0000_1218, 3'd1, 1, 1, 1, 4, -1, 0, 0);
        @(negedge clk); quiet();
        chk("R12 final idle", req_ready, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule